// File: doc/BRIEF.md
# Endpoint Request Header Router

This block sits on the receive side of a packet-based serial endpoint and decides, header by header, whether an incoming transaction packet is meant for this endpoint. Header dwords arrive one per cycle with a valid and a last marker. The router classifies the packet from its first dword. For address-routed packets it matches the request address against a set of programmable address windows. For ID-routed packets it matches the target bus/device/function against the endpoint's own identity. Locally routed messages are taken without either check.

The verdict is registered once the final header dword has been taken and stays on the outputs until the first dword of the next header is consumed. A rejected packet raises an unsupported-request flag. The tag and requester ID of the rejected packet are presented next to the flag, so that logic downstream can build the error completion. Each address window has its own base, power-of-two size and 32/64-bit mode. Windows are checked in index order, and the lowest index wins.

Top module: `tlp_rx_router`

## Requirements
- R1: After reset `resValid`, `resAccept` and `resUnsupported` are all low.
- R2: The result is valid on the cycle after the edge that takes the dword marked last. It is held unchanged while no header dword arrives. It drops on the cycle after the first dword of the next header is taken.
- R3: Bits 31:29 of dword 0 carry the format, and bit 29 set means a four-dword header. Bits 28:24 carry the type, and type `0000x` is a memory request. The address is dword 2 for three-dword headers and {dword 2, dword 3} for four-dword headers, with the low two bits forced to zero.
- R4: An address hits a window when all address bits at and above the window's size exponent equal the base. The exponent is raised to a minimum of 10 (1 KB). When several windows hit, the lowest index is reported on `resHitBar`.
- R5: A window in 32-bit mode treats its upper 32 base bits as zero. A four-dword address with nonzero upper bits therefore never hits it. A 64-bit window compares all 64 bits.
- R6: A window whose enable bit is low never hits. A memory request that hits no enabled window is rejected.
- R7: Config requests (type `0010x`), completions (type `0101x`) and ID-routed messages (type `10010`) are accepted only when dword 2 bits 31:16 equal `ownId`.
- R8: Messages of type `10rrr` whose routing code `rrr` is neither `001` nor `010` are accepted regardless of address and ID. Routing code `001` is address-routed exactly like a memory request.
- R9: Every rejection sets `resUnsupported`, and `resAccept` is then low. `resTag` shows dword 1 bits 15:8 and `resReqId` shows dword 1 bits 31:16 of that header.
- R10: Any other type code, including the I/O code `00010`, is rejected even when its address would hit a window.
- R11: A header that ends before the dword count its format demands (three or four) is rejected. Dwords after the required count are ignored.
- R12: `resHitBar` is 0 whenever the accepted packet is not an address hit, and also on rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | A header dword is present |
| hdrLast | input | 1 | The present dword is the last of the header |
| hdrData | input | 32 | Header dword |
| barBase | input | NUM_BARS*64 | Window base addresses, window i at bits i*64 +: 64 |
| barSizeLog2 | input | NUM_BARS*6 | Window size exponents, window i at bits i*6 +: 6 |
| barIs64 | input | NUM_BARS | Window uses 64-bit addressing |
| barEnable | input | NUM_BARS | Window is enabled |
| ownId | input | 16 | Endpoint bus[15:8], device[7:3], function[2:0] |
| resValid | output | 1 | Verdict outputs are valid |
| resAccept | output | 1 | Packet accepted |
| resUnsupported | output | 1 | Packet rejected as unsupported request |
| resHitBar | output | IDX_W | Index of the window that matched |
| resTag | output | 8 | Tag of the judged header |
| resReqId | output | 16 | Requester ID of the judged header |

## Verification
Memory requests are sent in both header lengths, against windows that overlap, windows of a clamped size, a disabled window and 64-bit windows. These cases separate priority, size clamping, enable gating and upper-address handling. Addresses just inside and just outside a window edge show whether the mask starts at the right bit. ID-routed packets are sent with a matching ID and with one differing only in the function number. Locally routed messages carry junk addresses, an I/O request hits a window, and headers come truncated and overlong, to show that the class decode and not the address decides the verdict. Idle gaps after each header test that the verdict is held.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;

  localparam int DW_W         = 32;
  localparam int ADDR_W       = 64;
  localparam int ID_W         = 16;
  localparam int TAG_W        = 8;
  localparam int SIZE_W       = 6;
  localparam int MIN_BAR_LOG2 = 10;
  localparam int HDR_MAX_DW   = 4;

  typedef enum logic [1:0] {
    ROUTE_ADDR,
    ROUTE_ID,
    ROUTE_IMPLICIT,
    ROUTE_NONE
  } route_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [HDR_MAX_DW-1:0] cap;    // capture dword k this cycle
    logic                  start;  // first dword of a header this cycle
    logic                  finish; // last dword of a header this cycle
    logic [2:0]            seen;   // dwords taken including this one, saturating
  } ctl_strobe_t;

  function automatic route_e classify(input logic [4:0] typ);
    route_e r;
    if (typ[4:1] == 4'b0000)      r = ROUTE_ADDR;
    else if (typ[4:1] == 4'b0010) r = ROUTE_ID;
    else if (typ[4:1] == 4'b0101) r = ROUTE_ID;
    else if (typ[4:3] == 2'b10) begin
      if (typ[2:0] == 3'b001)      r = ROUTE_ADDR;
      else if (typ[2:0] == 3'b010) r = ROUTE_ID;
      else                         r = ROUTE_IMPLICIT;
    end
    else                          r = ROUTE_NONE;
    return r;
  endfunction

endpackage

// File: rtl/tlp_rx_ctrl.sv
module tlp_rx_ctrl
  import tlp_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  input  logic        hdrLast,
  output ctl_strobe_t stb,
  output logic        resValid
);

  logic [2:0] wordIdx; // dwords already taken in the current header

  always_comb begin
    stb.start  = hdrValid && (wordIdx == 3'd0);
    stb.finish = hdrValid && hdrLast;
    for (int k = 0; k < HDR_MAX_DW; k++) begin
      stb.cap[k] = hdrValid && (wordIdx == 3'(k));
    end
    stb.seen = (wordIdx >= 3'(HDR_MAX_DW)) ? 3'(HDR_MAX_DW) : wordIdx + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx  <= 3'd0;
      resValid <= 1'b0;
    end else begin
      if (hdrValid) begin
        if (hdrLast)                             wordIdx <= 3'd0;
        else if (wordIdx < 3'(HDR_MAX_DW))       wordIdx <= wordIdx + 3'd1;
      end
      if (stb.finish)     resValid <= 1'b1;
      else if (stb.start) resValid <= 1'b0;
    end
  end

endmodule

// File: rtl/tlp_rx_dpath.sv
module tlp_rx_dpath
  import tlp_rx_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int IDX_W    = 3
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DW_W-1:0]              hdrData,
  input  ctl_strobe_t                  stb,
  input  logic [NUM_BARS*ADDR_W-1:0]   barBase,
  input  logic [NUM_BARS*SIZE_W-1:0]   barSizeLog2,
  input  logic [NUM_BARS-1:0]          barIs64,
  input  logic [NUM_BARS-1:0]          barEnable,
  input  logic [ID_W-1:0]              ownId,
  output logic                         resAccept,
  output logic                         resUnsupported,
  output logic [IDX_W-1:0]             resHitBar,
  output logic [TAG_W-1:0]             resTag,
  output logic [ID_W-1:0]              resReqId
);

  logic [DW_W-1:0] dwReg  [HDR_MAX_DW];
  logic [DW_W-1:0] dwView [HDR_MAX_DW];

  // Stored dwords, with the one arriving this cycle forwarded
  always_comb begin
    for (int k = 0; k < HDR_MAX_DW; k++) begin
      dwView[k] = stb.cap[k] ? hdrData : dwReg[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < HDR_MAX_DW; k++) dwReg[k] <= '0;
    end else begin
      for (int k = 0; k < HDR_MAX_DW; k++) begin
        if (stb.cap[k]) dwReg[k] <= hdrData;
      end
    end
  end

  // Header decode
  logic              is4Dw;
  route_e            route;
  logic              shortHdr;
  logic [ADDR_W-1:0] reqAddr;
  logic [ID_W-1:0]   targetId;

  always_comb begin
    is4Dw    = dwView[0][29];
    route    = classify(dwView[0][28:24]);
    shortHdr = stb.seen < (is4Dw ? 3'd4 : 3'd3);
    reqAddr  = is4Dw ? {dwView[2], dwView[3][31:2], 2'b00}
                     : {32'h0, dwView[2][31:2], 2'b00};
    targetId = dwView[2][31:16];
  end

  // One window comparator per BAR
  logic [NUM_BARS-1:0] barHit;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic [ADDR_W-1:0] baseRaw;
    logic [ADDR_W-1:0] baseEff;
    logic [ADDR_W-1:0] cmpMask;
    logic [6:0]        sizeEff;

    always_comb begin
      baseRaw = barBase[i*ADDR_W +: ADDR_W];
      baseEff = barIs64[i] ? baseRaw : {32'h0, baseRaw[31:0]};
      sizeEff = {1'b0, barSizeLog2[i*SIZE_W +: SIZE_W]};
      if (sizeEff < 7'(MIN_BAR_LOG2)) sizeEff = 7'(MIN_BAR_LOG2);
      if (!barIs64[i] && sizeEff > 7'd32) sizeEff = 7'd32;
      for (int b = 0; b < ADDR_W; b++) begin
        cmpMask[b] = (7'(b) >= sizeEff);
      end
      barHit[i] = barEnable[i] && (((reqAddr ^ baseEff) & cmpMask) == '0);
    end
  end

  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;

  always_comb begin
    anyHit = |barHit;
    hitIdx = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (barHit[i]) hitIdx = IDX_W'(i);
    end
  end

  // Verdict
  logic             nextAccept;
  logic [IDX_W-1:0] nextIdx;

  always_comb begin
    unique case (route)
      ROUTE_ADDR:     nextAccept = anyHit;
      ROUTE_ID:       nextAccept = (targetId == ownId);
      ROUTE_IMPLICIT: nextAccept = 1'b1;
      default:        nextAccept = 1'b0;
    endcase
    if (shortHdr) nextAccept = 1'b0;
    nextIdx = (nextAccept && route == ROUTE_ADDR) ? hitIdx : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resAccept      <= 1'b0;
      resUnsupported <= 1'b0;
      resHitBar      <= '0;
      resTag         <= '0;
      resReqId       <= '0;
    end else if (stb.finish) begin
      resAccept      <= nextAccept;
      resUnsupported <= !nextAccept;
      resHitBar      <= nextIdx;
      resTag         <= dwView[1][15:8];
      resReqId       <= dwView[1][31:16];
    end else if (stb.start) begin
      resAccept      <= 1'b0;
      resUnsupported <= 1'b0;
    end
  end

endmodule

// File: rtl/tlp_rx_router.sv
module tlp_rx_router
  import tlp_rx_pkg::*;
#(
  parameter int NUM_BARS = 6,
  localparam int IDX_W   = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hdrValid,
  input  logic                       hdrLast,
  input  logic [31:0]                hdrData,
  input  logic [NUM_BARS*64-1:0]     barBase,
  input  logic [NUM_BARS*6-1:0]      barSizeLog2,
  input  logic [NUM_BARS-1:0]        barIs64,
  input  logic [NUM_BARS-1:0]        barEnable,
  input  logic [15:0]                ownId,
  output logic                       resValid,
  output logic                       resAccept,
  output logic                       resUnsupported,
  output logic [IDX_W-1:0]           resHitBar,
  output logic [7:0]                 resTag,
  output logic [15:0]                resReqId
);

  ctl_strobe_t stb;

  tlp_rx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .hdrLast  (hdrLast),
    .stb      (stb),
    .resValid (resValid)
  );

  tlp_rx_dpath #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .hdrData        (hdrData),
    .stb            (stb),
    .barBase        (barBase),
    .barSizeLog2    (barSizeLog2),
    .barIs64        (barIs64),
    .barEnable      (barEnable),
    .ownId          (ownId),
    .resAccept      (resAccept),
    .resUnsupported (resUnsupported),
    .resHitBar      (resHitBar),
    .resTag         (resTag),
    .resReqId       (resReqId)
  );

endmodule

// File: rtl/tlp_rx_router_chk.sv
module tlp_rx_router_chk #(
  parameter int NUM_BARS = 6,
  parameter int IDX_W    = 3
)(
  input logic                clk,
  input logic                rstN,
  input logic                hdrValid,
  input logic                hdrLast,
  input logic [NUM_BARS-1:0] barEnable,
  input logic                resValid,
  input logic                resAccept,
  input logic                resUnsupported,
  input logic [IDX_W-1:0]    resHitBar,
  input logic [7:0]          resTag,
  input logic [15:0]         resReqId
);

  // R2
  result_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && hdrLast |=> resValid);

  // R2
  rise_needs_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(hdrValid && hdrLast));

  // R2
  result_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !hdrValid |=> resValid && $stable(resAccept) && $stable(resHitBar)
                              && $stable(resTag) && $stable(resReqId));

  // R9
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resAccept != resUnsupported));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !resAccept && !resUnsupported);

  // R6
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    resAccept && resHitBar != '0 |-> ((barEnable >> resHitBar) & 1) != 0);

endmodule

bind tlp_rx_router tlp_rx_router_chk #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .hdrValid       (hdrValid),
  .hdrLast        (hdrLast),
  .barEnable      (barEnable),
  .resValid       (resValid),
  .resAccept      (resAccept),
  .resUnsupported (resUnsupported),
  .resHitBar      (resHitBar),
  .resTag         (resTag),
  .resReqId       (resReqId)
);

// File: tb/tb_tlp_rx_router.sv
module tb_tlp_rx_router;

  localparam int NB = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN;
  logic             hdrValid, hdrLast;
  logic [31:0]      hdrData;
  logic [NB*64-1:0] barBase;
  logic [NB*6-1:0]  barSizeLog2;
  logic [NB-1:0]    barIs64, barEnable;
  logic [15:0]      ownId;
  logic             resValid, resAccept, resUnsupported;
  logic [IW-1:0]    resHitBar;
  logic [7:0]       resTag;
  logic [15:0]      resReqId;

  tlp_rx_router #(.NUM_BARS(NB)) dut (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrLast(hdrLast), .hdrData(hdrData),
    .barBase(barBase), .barSizeLog2(barSizeLog2), .barIs64(barIs64), .barEnable(barEnable),
    .ownId(ownId), .resValid(resValid), .resAccept(resAccept), .resUnsupported(resUnsupported),
    .resHitBar(resHitBar), .resTag(resTag), .resReqId(resReqId)
  );

  typedef struct {
    logic        acc;
    int          idx;
    logic [7:0]  tag;
    logic [15:0] rid;
    string       req;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  int   seq = 0;
  logic prevValid = 1'b0;
  logic done = 1'b0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops on each new verdict, compares while it is held
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (resValid) begin
        if (!prevValid) begin
          if (expQ.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2: verdict with nothing expected (acc=%0b exp none)", resAccept);
          end else begin
            cur = expQ.pop_front();
          end
        end
        checks++;
        if (resAccept !== cur.acc || resUnsupported !== !cur.acc ||
            resHitBar !== IW'(cur.idx) || resTag !== cur.tag || resReqId !== cur.rid) begin
          errors++;
          $display("FAIL %s: acc=%0b ur=%0b bar=%0d tag=%h rid=%h exp acc=%0b ur=%0b bar=%0d tag=%h rid=%h",
                   cur.req, resAccept, resUnsupported, resHitBar, resTag, resReqId,
                   cur.acc, !cur.acc, cur.idx, cur.tag, cur.rid);
        end
      end
      prevValid <= resValid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish (got timeout exp completion)");
    report();
  end

  task automatic idle(input int n);
    hdrValid = 1'b0; hdrLast = 1'b0; hdrData = '0;
    repeat (n) @(negedge clk);
  endtask

  // Driver: pushes the expected verdict, then streams the header
  task automatic sendHdr(input logic [31:0] d0, input logic [31:0] d2, input logic [31:0] d3,
                         input int len, input logic acc, input int idx, input string req);
    logic [31:0] w [5];
    exp_t e;
    seq++;
    w[0] = d0;
    w[1] = {16'h0100 + 16'(seq), 8'(seq), 8'h0F};
    w[2] = d2; w[3] = d3; w[4] = 32'hFFFF_FFFF;
    e.acc = acc; e.idx = idx; e.tag = 8'(seq); e.rid = 16'h0100 + 16'(seq); e.req = req;
    expQ.push_back(e);
    for (int i = 0; i < len; i++) begin
      hdrValid = 1'b1; hdrData = w[i]; hdrLast = (i == len - 1);
      @(negedge clk);
      if (i == 0 && len > 1) begin
        checks++;
        if (resValid !== 1'b0) begin
          errors++;
          $display("FAIL R2: resValid=%0b after first dword, exp 0", resValid);
        end
      end
    end
    idle(4);
  endtask

  initial begin
    rstN = 1'b0; hdrValid = 1'b0; hdrLast = 1'b0; hdrData = '0;
    barBase = '0; barSizeLog2 = '0;
    barBase[0*64 +: 64] = 64'h0000_0000_8000_0000; barSizeLog2[0*6 +: 6] = 6'd12;
    barBase[1*64 +: 64] = 64'h0000_0012_3400_0000; barSizeLog2[1*6 +: 6] = 6'd20;
    barBase[2*64 +: 64] = 64'h0000_0000_9000_0000; barSizeLog2[2*6 +: 6] = 6'd4;
    barBase[3*64 +: 64] = 64'h0000_0000_A000_0000; barSizeLog2[3*6 +: 6] = 6'd12;
    barBase[4*64 +: 64] = 64'h0000_0000_B000_0000; barSizeLog2[4*6 +: 6] = 6'd16;
    barBase[5*64 +: 64] = 64'h0000_0000_8000_0000; barSizeLog2[5*6 +: 6] = 6'd16;
    barIs64   = 6'b010010;
    barEnable = 6'b110111;
    ownId     = 16'h3A28;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (resValid !== 1'b0 || resAccept !== 1'b0 || resUnsupported !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b acc=%0b ur=%0b exp 0 0 0", resValid, resAccept, resUnsupported);
    end

    // R3/R4: 3DW memory read, overlapping windows 0 and 5, lowest wins
    sendHdr(32'h0000_0001, 32'h8000_0010, 32'h0, 3, 1'b1, 0, "R4");
    // R3: 4DW memory write to a 64-bit window
    sendHdr(32'h6000_0001, 32'h0000_0012, 32'h3400_5678, 4, 1'b1, 1, "R3");
    // R5: 4DW with nonzero upper half misses 32-bit windows
    sendHdr(32'h2000_0001, 32'h0000_0001, 32'h8000_0010, 4, 1'b0, 0, "R5");
    // R3: 4DW with zero upper half reaches a 32-bit window
    sendHdr(32'h2000_0001, 32'h0000_0000, 32'h8000_2000, 4, 1'b1, 5, "R3");
    // R4: size exponent clamped to 1 KB
    sendHdr(32'h0000_0001, 32'h9000_0300, 32'h0, 3, 1'b1, 2, "R4");
    sendHdr(32'h0000_0001, 32'h9000_0400, 32'h0, 3, 1'b0, 0, "R4");
    // R4: just outside window 0, inside window 5
    sendHdr(32'h0000_0001, 32'h8000_1000, 32'h0, 3, 1'b1, 5, "R4");
    // R6: disabled window never hits
    sendHdr(32'h0000_0001, 32'hA000_0010, 32'h0, 3, 1'b0, 0, "R6");
    // R5: 64-bit window reached with a 3DW header
    sendHdr(32'h0000_0001, 32'hB000_FFFC, 32'h0, 3, 1'b1, 4, "R5");
    // R7: config request match and function mismatch
    sendHdr(32'h0400_0001, 32'h3A28_0010, 32'h0, 3, 1'b1, 0, "R7");
    sendHdr(32'h0400_0001, 32'h3A29_0010, 32'h0, 3, 1'b0, 0, "R7");
    // R7: completion routed by ID
    sendHdr(32'h4A00_0001, 32'h3A28_0004, 32'h0, 3, 1'b1, 0, "R7");
    // R8/R12: locally routed message, junk address
    sendHdr(32'h3400_0000, 32'hDEAD_BEEF, 32'hA000_0000, 4, 1'b1, 0, "R8");
    // R7: ID-routed message, mismatch and match
    sendHdr(32'h3200_0000, 32'h1111_0000, 32'h0, 4, 1'b0, 0, "R7");
    sendHdr(32'h3200_0000, 32'h3A28_0000, 32'h0, 4, 1'b1, 0, "R7");
    // R8: address-routed message
    sendHdr(32'h3100_0000, 32'h0000_0000, 32'h8000_2004, 4, 1'b1, 5, "R8");
    // R10: I/O request rejected though the address hits
    sendHdr(32'h0200_0001, 32'h8000_0010, 32'h0, 3, 1'b0, 0, "R10");
    // R11: truncated 3DW and 4DW headers
    sendHdr(32'h0000_0001, 32'h8000_0010, 32'h0, 2, 1'b0, 0, "R11");
    sendHdr(32'h2000_0001, 32'h0000_0000, 32'h8000_0010, 3, 1'b0, 0, "R11");
    // R11: extra dwords ignored
    sendHdr(32'h0000_0001, 32'h8000_0010, 32'h5555_5555, 5, 1'b1, 0, "R11");
    // R9/R2: rejection then a long hold
    sendHdr(32'h0000_0001, 32'hC000_0000, 32'h0, 3, 1'b0, 0, "R9");
    idle(8);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d verdicts missing, exp 0", expQ.size());
    end
    done = 1'b1;
    report();
  end

endmodule